// File: doc/BRIEF.md
# Redundant Bus Receiver Supervisor

This block watches three receivers attached to one two-wire bus: a differential receiver that uses both wires, and one single-ended receiver on each wire (wire A and wire B). It finds wires that are shorted or open and passes the most trustworthy receive bit to the frame receiver. Two independent checks feed this decision. A periodic check counts the edges seen on the receive bit during each diagnosis period. A transmit-time check compares each single-ended receiver with the node's own transmitted bit at every 0-to-1 step that the node drives.

A two-bit mode input either forces one receiver or lets the block choose one from the fault flags. A new selection never takes effect while a frame is being sent, so a frame in progress keeps one source from start to end. Polarity bits adapt the block to inverting line drivers and receivers. A return-to-idle pulse clears the sticky diagnosis and restarts the period.

The diagnosis period must be set longer than the largest gap between frames on the network, so that a quiet bus between frames does not raise an error.

Top module: `bus_src_diag`

## Requirements
- R1: Mode 2'b00 selects the differential receiver, mode 2'b01 selects wire B, and mode 2'b10 selects wire A. `src_sel` reports the source as 0 for differential, 1 for wire A and 2 for wire B. `rx_sel` carries the selected receiver's bit.
- R2: In mode 2'b11, the block uses the differential receiver when neither wire is faulty and the healthy wire when exactly one wire is faulty. When both wires are faulty it uses the differential receiver again.
- R3: `src_sel` can change only on a clock edge at which `tx_busy` is low, and it then takes its new value on that same edge. While `tx_busy` is high, it holds its value even if the mode or the faults change.
- R4: A diagnosis period is 2^(`div_sel`+6) cycles in which `tick` is high. Cycles in which `tick` is low do not advance the period. `div_sel`=4'b0111 gives 8192 ticks.
- R5: At the end of each period, the block counts the edges on the selected receive bit during that period. If there are fewer than 4, it sets the major-error bit. Four or more edges leave the bit clear. Once set, the bit stays set until it is cleared.
- R6: A comparison happens only in a cycle where `tx_busy` is high and `tx_bit` rises from 0 to 1. In that cycle, a wire whose logical receive bit differs from `tx_bit` gets its fault bit set, and the bit stays set. A 1-to-0 step, or any step with `tx_busy` low, never sets a fault.
- R7: An `idle_pulse` clears all status bits on the next edge. It also restarts the diagnosis period and the edge count. Any edge present in the cycle of the pulse is not counted.
- R8: When `inv_rx` is 1, all three receive inputs are inverted before any selection or check. `tx_line` equals `tx_bit` XOR `inv_tx`.
- R9: `diag_status` is {major, fault_b, fault_a}, with fault_a in bit 0. The major bit is also set while both wires are faulty.
- R10: A synchronous reset selects the differential source, clears `diag_status` and restarts the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_diff | input | 1 | Differential receiver output |
| rx_a | input | 1 | Single-ended receiver on wire A |
| rx_b | input | 1 | Single-ended receiver on wire B |
| tx_bit | input | 1 | Logical transmitted bit (1 = recessive) |
| tx_busy | input | 1 | Transmission in progress |
| idle_pulse | input | 1 | Return-to-idle pulse; clears the diagnosis |
| tick | input | 1 | Prescaled diagnosis clock enable |
| div_sel | input | 4 | Period exponent selector |
| mode | input | 2 | Source mode |
| inv_rx | input | 1 | Invert the receive inputs |
| inv_tx | input | 1 | Invert the transmit output |
| tx_line | output | 1 | Transmit bit to the line driver |
| rx_sel | output | 1 | Selected logical receive bit |
| src_sel | output | 2 | Current source code |
| diag_status | output | 3 | {major, fault_b, fault_a} |

## Verification
The assertions assume that `idle_pulse` is a single-cycle pulse. They also assume that `tx_bit` and the single-ended inputs settle in the same cycle, so a correct wire echoes the transmitted bit with no delay. The bench drives every input at the falling edge and moves the echo together with `tx_bit`. It changes `mode` and `tx_busy` only between checks, and it starts every period-sensitive test with an idle pulse, so edge counts line up with a known period start.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int PERIOD_BASE_EXP = 6;
    localparam int MIN_EDGES       = 4;

    typedef enum logic [1:0] {
        SRC_DIFF   = 2'd0,
        SRC_WIRE_A = 2'd1,
        SRC_WIRE_B = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        MODE_DIFF   = 2'd0,
        MODE_ONLY_B = 2'd1,
        MODE_ONLY_A = 2'd2,
        MODE_AUTO   = 2'd3
    } mode_e;

    typedef struct packed {
        logic major;
        logic fault_b;
        logic fault_a;
    } diag_t;

    function automatic src_e pick_source(mode_e m, logic fa, logic fb);
        src_e s;
        case (m)
            MODE_ONLY_B: s = SRC_WIRE_B;
            MODE_ONLY_A: s = SRC_WIRE_A;
            MODE_AUTO: begin
                if (fa && !fb)      s = SRC_WIRE_B;
                else if (fb && !fa) s = SRC_WIRE_A;
                else                s = SRC_DIFF;
            end
            default:     s = SRC_DIFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bsd_period_timer.sv
module bsd_period_timer #(
    parameter int SEL_W    = 4,
    parameter int BASE_EXP = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [SEL_W-1:0] div_sel,
    output logic             period_end
);
    localparam int CNT_W = BASE_EXP + (1 << SEL_W);
    localparam int SH_W  = $clog2(CNT_W) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic [SH_W-1:0]  shamt;

    assign shamt      = SH_W'(div_sel) + SH_W'(BASE_EXP);
    assign last       = (CNT_W'(1) << shamt) - CNT_W'(1);
    assign period_end = tick && !restart && (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q >= last) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    p_period_spaced_r4: assert property (@(posedge clk) disable iff (rst)
        period_end |=> !period_end);

endmodule

// File: rtl/bsd_edge_check.sv
module bsd_edge_check #(
    parameter int MIN_EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic rx,
    input  logic period_end,
    output logic major
);
    localparam int CW = $clog2(MIN_EDGES + 1) + 1;

    logic          prev_q;
    logic [CW-1:0] cnt_q;
    logic          major_q;
    logic          edge_now;
    logic [CW-1:0] total;

    assign edge_now = rx ^ prev_q;
    assign total    = cnt_q + CW'(edge_now);
    assign major    = major_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= rx;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q   <= '0;
            major_q <= 1'b0;
        end else if (period_end) begin
            if (total < CW'(MIN_EDGES)) major_q <= 1'b1;
            cnt_q <= '0;
        end else if (edge_now && (cnt_q < CW'(MIN_EDGES))) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    p_major_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (major && !clear) |=> major);

    p_major_at_period_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(major) |-> $past(period_end));

endmodule

// File: rtl/bsd_tx_check.sv
module bsd_tx_check (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tx_busy,
    input  logic tx_bit,
    input  logic rx_a,
    input  logic rx_b,
    output logic fault_a,
    output logic fault_b
);
    logic prev_tx_q;
    logic compare;

    assign compare = tx_busy && !prev_tx_q && tx_bit;

    always_ff @(posedge clk) begin
        if (rst) prev_tx_q <= 1'b1;
        else     prev_tx_q <= tx_bit;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fault_a <= 1'b0;
            fault_b <= 1'b0;
        end else if (compare) begin
            if (rx_a != tx_bit) fault_a <= 1'b1;
            if (rx_b != tx_bit) fault_b <= 1'b1;
        end
    end

    p_fault_a_needs_tx_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_a) |-> ($past(tx_busy) && $past(tx_bit)));

    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (fault_b && !clear) |=> fault_b);

endmodule

// File: rtl/bus_src_diag.sv
module bus_src_diag
    import bsd_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_diff,
    input  logic             rx_a,
    input  logic             rx_b,
    input  logic             tx_bit,
    input  logic             tx_busy,
    input  logic             idle_pulse,
    input  logic             tick,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [1:0]       mode,
    input  logic             inv_rx,
    input  logic             inv_tx,
    output logic             tx_line,
    output logic             rx_sel,
    output logic [1:0]       src_sel,
    output logic [2:0]       diag_status
);
    logic  d_log, a_log, b_log;
    logic  period_end;
    logic  major_edge;
    logic  fault_a, fault_b;
    src_e  src_q;
    src_e  src_want;
    diag_t status;

    // polarity adaptation
    assign d_log   = rx_diff ^ inv_rx;
    assign a_log   = rx_a    ^ inv_rx;
    assign b_log   = rx_b    ^ inv_rx;
    assign tx_line = tx_bit  ^ inv_tx;

    bsd_period_timer #(
        .SEL_W    (SEL_W),
        .BASE_EXP (PERIOD_BASE_EXP)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .restart    (idle_pulse),
        .tick       (tick),
        .div_sel    (div_sel),
        .period_end (period_end)
    );

    bsd_edge_check #(
        .MIN_EDGES (MIN_EDGES)
    ) u_edges (
        .clk        (clk),
        .rst        (rst),
        .clear      (idle_pulse),
        .rx         (rx_sel),
        .period_end (period_end),
        .major      (major_edge)
    );

    bsd_tx_check u_txchk (
        .clk     (clk),
        .rst     (rst),
        .clear   (idle_pulse),
        .tx_busy (tx_busy),
        .tx_bit  (tx_bit),
        .rx_a    (a_log),
        .rx_b    (b_log),
        .fault_a (fault_a),
        .fault_b (fault_b)
    );

    // source choice, applied only between frames
    assign src_want = pick_source(mode_e'(mode), fault_a, fault_b);

    always_ff @(posedge clk) begin
        if (rst)           src_q <= SRC_DIFF;
        else if (!tx_busy) src_q <= src_want;
    end

    always_comb begin
        case (src_q)
            SRC_WIRE_A: rx_sel = a_log;
            SRC_WIRE_B: rx_sel = b_log;
            default:    rx_sel = d_log;
        endcase
    end

    assign status.major   = major_edge | (fault_a & fault_b);
    assign status.fault_b = fault_b;
    assign status.fault_a = fault_a;
    assign diag_status    = status;
    assign src_sel        = src_q;

    p_src_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        tx_busy |=> $stable(src_sel));

    p_forced_diff_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && !tx_busy) |=> (src_sel == 2'd0));

    p_auto_avoid_a_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && !tx_busy && fault_a && !fault_b) |=> (src_sel == 2'd2));

    p_idle_clear_r7: assert property (@(posedge clk) disable iff (rst)
        idle_pulse |=> (diag_status == 3'b000));

    p_src_legal_r1: assert property (@(posedge clk) disable iff (rst)
        src_sel != 2'd3);

endmodule

// File: tb/test_bus_src_diag.sv
`timescale 1ns/1ps
module test_bus_src_diag;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_diff = 1'b1, rx_a = 1'b1, rx_b = 1'b1;
    logic       tx_bit = 1'b1, tx_busy = 1'b0, idle_pulse = 1'b0, tick = 1'b1;
    logic [3:0] div_sel = 4'd0;
    logic [1:0] mode = 2'b00;
    logic       inv_rx = 1'b0, inv_tx = 1'b0;
    logic       tx_line, rx_sel;
    logic [1:0] src_sel;
    logic [2:0] diag_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    bus_src_diag i_bus_src_diag (
        .clk(clk), .rst(rst), .rx_diff(rx_diff), .rx_a(rx_a), .rx_b(rx_b),
        .tx_bit(tx_bit), .tx_busy(tx_busy), .idle_pulse(idle_pulse), .tick(tick),
        .div_sel(div_sel), .mode(mode), .inv_rx(inv_rx), .inv_tx(inv_tx),
        .tx_line(tx_line), .rx_sel(rx_sel), .src_sel(src_sel), .diag_status(diag_status)
    );

    // {mode[1:0], rx_diff, rx_a, rx_b, exp_src[1:0], exp_rx}
    localparam logic [7:0] VEC [7] = '{
        8'b00_100_00_1, 8'b00_011_00_0,
        8'b01_001_10_1, 8'b01_110_10_0,
        8'b10_010_01_1, 8'b10_101_01_0,
        8'b11_100_00_1
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_rx(input logic d, input logic a, input logic b);
        rx_diff = d; rx_a = a; rx_b = b;
    endtask

    task automatic go_idle();
        @(negedge clk) idle_pulse = 1'b1;
        @(negedge clk) idle_pulse = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R10 reset state
        chk("R10 src after reset", src_sel, 0);
        chk("R10 status after reset", diag_status, 0);
        chk("R10 rx_sel follows diff", rx_sel, rx_diff);

        // R1 / R2 vector table
        for (int i = 0; i < 7; i++) begin
            mode = VEC[i][7:6];
            set_rx(VEC[i][5], VEC[i][4], VEC[i][3]);
            cyc(1);
            chk($sformatf("R1 vec%0d src", i), src_sel, VEC[i][2:1]);
            chk($sformatf("R1 vec%0d rx", i), rx_sel, VEC[i][0]);
        end

        // R5: three edges in a period -> major
        mode = 2'b00; set_rx(1, 1, 1);
        cyc(1);
        go_idle();
        for (int k = 0; k < 3; k++) begin
            set_rx(~rx_diff, ~rx_a, ~rx_b);
            cyc(1);
        end
        cyc(59);
        chk("R5 no major before period end", diag_status[2], 0);
        cyc(3);
        chk("R5 three edges -> major", diag_status[2], 1);

        // R5/R7: four edges -> no major
        go_idle();
        chk("R7 idle clears major", diag_status, 0);
        for (int k = 0; k < 4; k++) begin
            set_rx(~rx_diff, ~rx_a, ~rx_b);
            cyc(1);
        end
        cyc(62);
        chk("R5 four edges -> no major", diag_status[2], 0);

        // R4: tick gating doubles the period
        go_idle();
        for (int k = 0; k < 130; k++) begin
            tick = (k % 2 == 0);
            cyc(1);
            if (k == 119) chk("R4 gated tick, before end", diag_status[2], 0);
        end
        chk("R4 gated tick, after end", diag_status[2], 1);
        tick = 1'b1;

        // R4: div_sel=1 -> 128 ticks
        div_sel = 4'd1;
        go_idle();
        cyc(120);
        chk("R4 div1 before end", diag_status[2], 0);
        cyc(10);
        chk("R4 div1 after end", diag_status[2], 1);
        div_sel = 4'd0;

        // R6 / R3 / R2 / R9 transmit-time check in auto mode
        mode = 2'b11;
        go_idle();
        tx_busy = 1'b1; tx_bit = 1'b1; set_rx(1, 1, 1);
        cyc(1);
        tx_bit = 1'b0; set_rx(0, 0, 1);
        cyc(1);
        chk("R6 falling step never flags", diag_status[1:0], 0);
        tx_bit = 1'b1; set_rx(1, 0, 1);
        cyc(1);
        chk("R6 wire A mismatch flagged", diag_status[1:0], 1);
        chk("R3 src held while busy", src_sel, 0);
        tx_busy = 1'b0; set_rx(0, 0, 1);
        cyc(1);
        chk("R2 auto picks wire B", src_sel, 2);
        chk("R2 rx_sel from wire B", rx_sel, 1);
        tx_bit = 1'b0; set_rx(0, 0, 0);
        cyc(1);
        tx_bit = 1'b1; set_rx(1, 1, 0);
        cyc(1);
        chk("R6 no compare when not busy", diag_status[1], 0);
        tx_busy = 1'b1; tx_bit = 1'b0; set_rx(0, 0, 0);
        cyc(1);
        tx_bit = 1'b1; set_rx(1, 1, 0);
        cyc(1);
        chk("R6 wire B mismatch flagged", diag_status[1:0], 3);
        chk("R3 src held with both faults", src_sel, 2);
        tx_busy = 1'b0;
        cyc(1);
        chk("R2 both faulty -> diff", src_sel, 0);
        chk("R9 status both faulty", diag_status, 7);
        go_idle();
        chk("R7 idle clears status", diag_status, 0);
        chk("R7 src diff after idle", src_sel, 0);

        // R8 polarity
        mode = 2'b00; inv_rx = 1'b1; set_rx(0, 1, 1);
        cyc(1);
        chk("R8 inverted rx", rx_sel, 1);
        inv_tx = 1'b1; tx_bit = 1'b0;
        #1;
        chk("R8 inverted tx", tx_line, 1);
        go_idle();
        tx_busy = 1'b1; tx_bit = 1'b0; set_rx(1, 1, 1);
        cyc(1);
        tx_bit = 1'b1; set_rx(0, 0, 0);
        cyc(1);
        chk("R8 inverted echo is healthy", diag_status[1:0], 0);

        // R1/R3 forced mode change held while busy
        inv_rx = 1'b0; inv_tx = 1'b0;
        mode = 2'b10;
        cyc(1);
        chk("R3 forced change held while busy", src_sel, 0);
        tx_busy = 1'b0;
        cyc(1);
        chk("R1 mode 10 selects wire A", src_sel, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule